// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block sits beside the command path of an SDRAM controller and watches every command that goes out to the device. For each bank it keeps a small state machine that follows the bank from idle through row activation, an optional pending auto precharge, and precharge recovery back to idle. Every cycle it says, for each bank, whether the command now presented is allowed for that bank. It also keeps a sticky flag that records any illegal command it has seen.

The minimum row-active time and the precharge recovery time are given as picosecond parameters. They are turned into clock counts by dividing by the clock period and rounding up. With the defaults (7500 ps clock, 42000 ps row-active, 18000 ps recovery, burst of 4), this gives a row-active time of 6 cycles and a recovery time of 3 cycles.

Each bank machine has four states:
- `BK_IDLE`: the bank has no open row.
- `BK_ACTIVE`: a row is open.
- `BK_AP_WAIT`: a row is open and an auto precharge is pending.
- `BK_PRECHG`: precharge recovery is running.

The machine moves between these states on six transitions:
- activate: `BK_IDLE` to `BK_ACTIVE`.
- access with auto precharge: `BK_ACTIVE` to `BK_AP_WAIT`.
- explicit precharge: `BK_ACTIVE` to `BK_PRECHG`.
- internal precharge start: `BK_AP_WAIT` to `BK_PRECHG`.
- recovery done: `BK_PRECHG` to `BK_IDLE`.
- hold: stay in the current state.

When the recovery time is a single cycle, a precharge start goes straight to `BK_IDLE`.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is held and just after it is released, every bank reports idle (00). The violation flag is 0, and a no-operation command is legal for all banks.
- R2: Commands are decoded with chip select low, from {ras_n,cas_n,we_n}:
  - 011 is activate.
  - 101 is read and 100 is write; a10=1 on either asks for auto precharge.
  - 010 is precharge; a10=0 precharges the addressed bank and a10=1 precharges all banks.
  - With chip select high, the command is a deselect, whatever the other pins hold.
- R3: The state of bank i is output on bank_state[2i+1:2i] as a 2-bit code: 00 idle, 01 active, 10 precharging, 11 active with auto precharge pending. A legal activate to an idle bank shows 01 from the next cycle on.
- R4: A precharge to an active bank is legal only when at least RAS_CYC cycles have passed since its activate, so that the activate is in cycle a and the precharge is in cycle a+RAS_CYC or later. RAS_CYC = ceil(T_RAS_PS/CLK_PERIOD_PS).
- R5: After an accepted precharge in cycle p, the bank shows 10 for cycles p+1 up to p+RP_CYC-1 and idle from cycle p+RP_CYC. RP_CYC = ceil(T_RP_PS/CLK_PERIOD_PS).
- R6: A read or write with auto precharge in cycle r, to a bank activated in cycle a, works as follows:
  - The bank shows 11 until the internal precharge starts.
  - The internal precharge starts in cycle s = max(r+BURST_LEN, a+RAS_CYC).
  - The bank then shows 10, and is idle from cycle s+RP_CYC.
- R7: While a bank is precharging or has an auto precharge pending, every activate, read, write or precharge that addresses it is illegal, and so is any precharge-all.
- R8: A precharge-all is legal only when every bank is idle or active with its row-active time met. When it is accepted, every active bank starts precharging and idle banks stay idle.
- R9: Activate is legal only to an idle bank. Read and write are legal only to an active bank.
- R10: An illegal command changes no bank state and disturbs no timer. A rejected precharge-all precharges no bank.
- R11: cmd_legal[i] is 0 only when the command presented this cycle addresses bank i (a precharge-all addresses every bank) and is illegal for it. The violation flag rises in the cycle after any illegal command and stays at 1 until reset.
- R12: Deselect, no-operation, refresh, mode-register load and burst stop are legal and have no effect. A precharge to an idle bank is legal and leaves it idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select of the issued command, active low |
| ras_n | input | 1 | Row strobe of the issued command, active low |
| cas_n | input | 1 | Column strobe of the issued command, active low |
| we_n | input | 1 | Write enable of the issued command, active low |
| bank | input | BANK_W | Bank address of the issued command |
| a10 | input | 1 | Auto precharge / all-banks select bit |
| bank_state | output | 2*NUM_BANKS | Per-bank 2-bit state code |
| cmd_legal | output | NUM_BANKS | Per-bank legality of the command presented now |
| violation | output | 1 | Sticky illegal-command flag |

## Verification
The bench aims at the start of the auto precharge. One case has the row-active minimum as the later limit and another has the burst end as the later limit. A design that started the precharge on only one of these limits would return the bank to idle a cycle early in one of the two cases.

It presents a precharge one cycle before the row-active time is met. It also presents a precharge-all while one bank is still short of that time. Both must be refused, and the refused precharge-all must leave the bank that is ready still open. A design that applied the precharge-all bank by bank would close that bank.

The bench also sends commands to banks that are busy precharging or waiting on an auto precharge, sends a read to an idle bank, and uses a deselect with an activate pattern on the strobes. In each of these cases the state must stay where it was.

// File: rtl/sdbk_pkg.sv
package sdbk_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'b00,
        BK_ACTIVE  = 2'b01,
        BK_PRECHG  = 2'b10,
        BK_AP_WAIT = 2'b11
    } bank_st_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_ACT,
        K_RW,
        K_RW_AP,
        K_PRE
    } cmd_kind_t;

    function automatic int ps_to_cyc(input int t_ps, input int per_ps);
        return (t_ps + per_ps - 1) / per_ps;
    endfunction

endpackage

// File: rtl/sdbk_cmd_decode.sv
module sdbk_cmd_decode
    import sdbk_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      a10,
    output cmd_kind_t kind,
    output logic      pre_all
);

    // R2: strobe decoding; refresh, mode load and burst stop are not tracked
    always_comb begin
        kind    = K_NONE;
        pre_all = 1'b0;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:         kind = K_ACT;
                3'b101, 3'b100: kind = a10 ? K_RW_AP : K_RW;
                3'b010: begin
                    kind    = K_PRE;
                    pre_all = a10;
                end
                default:        kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdbk_bank_fsm.sv
module sdbk_bank_fsm
    import sdbk_pkg::*;
#(
    parameter int RAS_CYC   = 6,
    parameter int RP_CYC    = 3,
    parameter int BURST_LEN = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_t kind,
    input  logic      hit,
    input  logic      apply,
    output logic      legal,
    output bank_st_t  state
);

    localparam int CNT_MAX = (RAS_CYC > BURST_LEN) ?
                             ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC) :
                             ((BURST_LEN > RP_CYC) ? BURST_LEN : RP_CYC);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] RAS_LD = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] BST_LD = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(RP_CYC - 1);
    localparam bank_st_t PRE_DEST = (RP_CYC > 1) ? BK_PRECHG : BK_IDLE;

    bank_st_t      st_q, st_d;
    logic [CW-1:0] ras_q, ras_d, bst_q, bst_d, rp_q, rp_d;
    logic          ras_met, bst_done, pre_go, ok;

    assign ras_met  = (ras_q == '0);
    assign bst_done = (bst_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            ras_q <= '0;
            bst_q <= '0;
            rp_q  <= '0;
        end else begin
            st_q  <= st_d;
            ras_q <= ras_d;
            bst_q <= bst_d;
            rp_q  <= rp_d;
        end
    end

    // next state and timers
    always_comb begin
        st_d   = st_q;
        ras_d  = ras_met  ? ras_q : ras_q - 1'b1;
        bst_d  = bst_done ? bst_q : bst_q - 1'b1;
        rp_d   = (rp_q == '0) ? rp_q : rp_q - 1'b1;
        pre_go = 1'b0;
        unique case (st_q)
            BK_IDLE: begin
                if (apply && kind == K_ACT) begin
                    st_d  = BK_ACTIVE;
                    ras_d = RAS_LD;
                end
            end
            BK_ACTIVE: begin
                if (apply && kind == K_RW_AP) begin
                    st_d  = BK_AP_WAIT;
                    bst_d = BST_LD;
                end else if (apply && kind == K_PRE) begin
                    pre_go = 1'b1;
                end
            end
            BK_AP_WAIT: begin
                if (ras_met && bst_done) pre_go = 1'b1;
            end
            BK_PRECHG: begin
                if (rp_q <= CW'(1)) st_d = BK_IDLE;
            end
        endcase
        if (pre_go) begin
            st_d = PRE_DEST;
            rp_d = RP_LD;
        end
    end

    // outputs
    always_comb begin
        unique case (kind)
            K_ACT:          ok = (st_q == BK_IDLE);
            K_RW, K_RW_AP:  ok = (st_q == BK_ACTIVE);
            K_PRE:          ok = (st_q == BK_IDLE) || (st_q == BK_ACTIVE && ras_met);
            default:        ok = 1'b1;
        endcase
        legal = !hit || ok;
        state = st_q;
    end

    assert_idle_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_IDLE) |=> (st_q inside {BK_IDLE, BK_ACTIVE}));
    assert_pre_after_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_ACTIVE && apply && kind == K_PRE) |-> ras_met);
    assert_busy_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {BK_AP_WAIT, BK_PRECHG}) |-> !apply);
    assert_reject_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !apply && st_q == BK_ACTIVE) |=> (st_q == BK_ACTIVE));
    assert_recovery_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_PRECHG) |=> (st_q inside {BK_PRECHG, BK_IDLE}));
    assert_rp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rp_q <= RP_LD);
    assert_ap_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_AP_WAIT && !(ras_met && bst_done)) |=> (st_q == BK_AP_WAIT));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdbk_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int CLK_PERIOD_PS = 7500,
    parameter int T_RAS_PS      = 42000,
    parameter int T_RP_PS       = 18000,
    parameter int BURST_LEN     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BANK_W-1:0]         bank,
    input  logic                      a10,
    output logic [2*(1<<BANK_W)-1:0]  bank_state,
    output logic [(1<<BANK_W)-1:0]    cmd_legal,
    output logic                      violation
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int RAS_CYC   = ps_to_cyc(T_RAS_PS, CLK_PERIOD_PS);
    localparam int RP_CYC    = ps_to_cyc(T_RP_PS, CLK_PERIOD_PS);

    cmd_kind_t             kind;
    logic                  pre_all, cmd_ok, viol_q;
    logic [NUM_BANKS-1:0]  hit, apply, is_active;

    sdbk_cmd_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .a10     (a10),
        .kind    (kind),
        .pre_all (pre_all)
    );

    // R8, R10: the command is applied only when every addressed bank accepts it
    assign cmd_ok = &cmd_legal;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        bank_st_t st;
        assign hit[i]   = (kind != K_NONE) && (pre_all || bank == BANK_W'(i));
        assign apply[i] = hit[i] && cmd_ok;
        sdbk_bank_fsm #(
            .RAS_CYC   (RAS_CYC),
            .RP_CYC    (RP_CYC),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .kind  (kind),
            .hit   (hit[i]),
            .apply (apply[i]),
            .legal (cmd_legal[i]),
            .state (st)
        );
        assign bank_state[2*i +: 2] = st;
        assign is_active[i]         = (st == BK_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_q | ~cmd_ok;
    end
    assign violation = viol_q;

    assert_viol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    assert_viol_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> violation);
    assert_preall_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_PRE && pre_all && cmd_ok) |=> (is_active == '0));

endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] bank;
    logic [7:0] bank_state;
    logic [3:0] cmd_legal;
    logic       violation;
    int         tests = 0;
    int         fails = 0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sdram_bank_tracker u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .bank       (bank),
        .a10        (a10),
        .bank_state (bank_state),
        .cmd_legal  (cmd_legal),
        .violation  (violation)
    );

    // op codes: 0 nop, 1 act, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode, 7 deselect
    // entry: {op[2:0], bank[1:0], a10, expected state[7:0], expected legal[3:0], req[3:0]}
    // defaults give 6 cycles row-active, 3 cycles recovery, burst 4
    localparam int NV = 34;
    localparam logic [21:0] VEC [NV] = '{
        {3'd1, 2'd0, 1'b0, 8'h00, 4'hF, 4'd3},  // c0  act b0, R3
        {3'd2, 2'd0, 1'b1, 8'h01, 4'hF, 4'd2},  // c1  read+ap b0, R2
        {3'd0, 2'd0, 1'b0, 8'h03, 4'hF, 4'd6},  // c2  R6 pending
        {3'd1, 2'd0, 1'b0, 8'h03, 4'hE, 4'd7},  // c3  act to pending bank, R7
        {3'd1, 2'd1, 1'b0, 8'h03, 4'hF, 4'd3},  // c4  act b1, R3
        {3'd4, 2'd0, 1'b0, 8'h07, 4'hE, 4'd7},  // c5  pre to pending bank, R7
        {3'd0, 2'd0, 1'b0, 8'h07, 4'hF, 4'd6},  // c6  R6 start cycle (row-active later)
        {3'd0, 2'd0, 1'b0, 8'h06, 4'hF, 4'd6},  // c7  R6 precharging
        {3'd0, 2'd0, 1'b0, 8'h06, 4'hF, 4'd6},  // c8  R6
        {3'd4, 2'd1, 1'b0, 8'h04, 4'hD, 4'd4},  // c9  pre b1 one cycle early, R4
        {3'd4, 2'd1, 1'b0, 8'h04, 4'hF, 4'd10}, // c10 b1 untouched, pre now legal, R10
        {3'd3, 2'd1, 1'b0, 8'h08, 4'hD, 4'd7},  // c11 write to precharging bank, R7
        {3'd1, 2'd2, 1'b0, 8'h08, 4'hF, 4'd5},  // c12 R5 still recovering
        {3'd1, 2'd3, 1'b0, 8'h10, 4'hF, 4'd5},  // c13 R5 b1 idle
        {3'd4, 2'd0, 1'b1, 8'h50, 4'h3, 4'd8},  // c14 pre-all too early, R8
        {3'd3, 2'd2, 1'b0, 8'h50, 4'hF, 4'd10}, // c15 banks still open, R10
        {3'd0, 2'd0, 1'b0, 8'h50, 4'hF, 4'd9},  // c16 R9
        {3'd0, 2'd0, 1'b0, 8'h50, 4'hF, 4'd9},  // c17 R9
        {3'd4, 2'd0, 1'b1, 8'h50, 4'h7, 4'd8},  // c18 b3 short by one, R8
        {3'd4, 2'd0, 1'b1, 8'h50, 4'hF, 4'd10}, // c19 b2 kept open, pre-all legal, R10
        {3'd1, 2'd0, 1'b0, 8'hA0, 4'hF, 4'd8},  // c20 both precharging, R8
        {3'd2, 2'd2, 1'b0, 8'hA1, 4'hB, 4'd7},  // c21 read to precharging bank, R7
        {3'd0, 2'd0, 1'b0, 8'h01, 4'hF, 4'd8},  // c22 R8 all idle again
        {3'd3, 2'd0, 1'b1, 8'h01, 4'hF, 4'd6},  // c23 write+ap b0, R6 burst later
        {3'd0, 2'd0, 1'b0, 8'h03, 4'hF, 4'd6},  // c24 R6
        {3'd0, 2'd0, 1'b0, 8'h03, 4'hF, 4'd6},  // c25 R6
        {3'd4, 2'd0, 1'b1, 8'h03, 4'hE, 4'd7},  // c26 pre-all with pending bank, R7
        {3'd0, 2'd0, 1'b0, 8'h03, 4'hF, 4'd6},  // c27 R6 start cycle
        {3'd0, 2'd0, 1'b0, 8'h02, 4'hF, 4'd6},  // c28 R6
        {3'd5, 2'd0, 1'b0, 8'h02, 4'hF, 4'd12}, // c29 refresh ignored, R12
        {3'd6, 2'd0, 1'b0, 8'h00, 4'hF, 4'd12}, // c30 mode load ignored, R12
        {3'd7, 2'd0, 1'b0, 8'h00, 4'hF, 4'd12}, // c31 deselect, R12
        {3'd4, 2'd1, 1'b0, 8'h00, 4'hF, 4'd12}, // c32 pre to idle bank, R12
        {3'd0, 2'd0, 1'b0, 8'h00, 4'hF, 4'd12}  // c33 R12 still idle
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [1:0] ba, input logic ap);
        @(negedge clk);
        bank = ba;
        a10  = ap;
        cs_n = (op == 3'd7);
        case (op)
            3'd1:    {ras_n, cas_n, we_n} = 3'b011;
            3'd2:    {ras_n, cas_n, we_n} = 3'b101;
            3'd3:    {ras_n, cas_n, we_n} = 3'b100;
            3'd4:    {ras_n, cas_n, we_n} = 3'b010;
            3'd5:    {ras_n, cas_n, we_n} = 3'b001;
            3'd6:    {ras_n, cas_n, we_n} = 3'b000;
            3'd7:    {ras_n, cas_n, we_n} = 3'b011;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n, a10} = 5'b01111;
        bank = '0;
        drive(3'd0, 2'd0, 1'b0);
        drive(3'd0, 2'd0, 1'b0);
        chk(32'(bank_state), 32'h00, "R1 state in reset");
        chk(32'(violation), 32'h0, "R1 violation in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(32'(bank_state), 32'h00, "R1 state after reset");
        chk(32'(cmd_legal), 32'hF, "R1 nop legal");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][21:19], VEC[i][18:17], VEC[i][16]);
            chk(32'(bank_state), 32'(VEC[i][15:8]), $sformatf("R%0d state row %0d", VEC[i][3:0], i));
            chk(32'(cmd_legal), 32'(VEC[i][7:4]), $sformatf("R%0d legal row %0d", VEC[i][3:0], i));
        end
        chk(32'(violation), 32'h1, "R11 sticky after table");

        // reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        drive(3'd0, 2'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(32'(violation), 32'h0, "R1 violation cleared");
        chk(32'(bank_state), 32'h00, "R1 banks idle");

        // read to idle bank
        drive(3'd2, 2'd0, 1'b0);
        chk(32'(cmd_legal), 32'hE, "R9 read to idle bank");
        chk(32'(violation), 32'h0, "R11 flag registered");
        drive(3'd0, 2'd0, 1'b0);
        chk(32'(violation), 32'h1, "R11 flag raised");
        chk(32'(bank_state), 32'h00, "R10 rejected read no effect");

        // deselect with activate strobes
        drive(3'd7, 2'd2, 1'b0);
        chk(32'(cmd_legal), 32'hF, "R2 deselect legal");
        drive(3'd0, 2'd0, 1'b0);
        chk(32'(bank_state), 32'h00, "R2 deselect no activate");
        drive(3'd0, 2'd0, 1'b0);
        chk(32'(violation), 32'h1, "R11 flag held");

        finish_run();
    end

endmodule